// File: doc/BRIEF.md
# Video Memory Host Write Port

This block sits between a host bus and the video memories. The host first loads a destination address, then streams data words into a small write queue. A drain engine takes one word per cycle whenever the video memory arbiter grants the port access. It decodes the current destination into the pattern RAM, the sprite RAM or the palette RAM and pulses the write strobe of that RAM. It then steps the destination to the next location. Words aimed at unmapped space are dropped, but the destination still steps.

The 16-bit destination space has five parts. Addresses with bit 15 clear reach the 32K-word pattern RAM, one word per address. With bit 15 set, bits 14:8 choose a page. Page 0x7E (0xFExx) is the sprite RAM and page 0x7F (0xFFxx) is the palette RAM, whose upper half mirrors the lower half. All other pages are unused. In any page, the low byte is a byte offset whose bit 0 is ignored.

The data stream uses valid/ready. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue is full. The host must hold `in_valid` and `in_data` steady until the word is taken. A new destination written while older words are still queued waits until those words have drained.

Top module: `vram_host_port`

## Requirements
- R1: After reset the queue is empty, the destination is 0x0000 and no write strobe is active.
- R2: The queue holds 4 words. `in_ready` is low exactly when it is full. A word offered while the queue is full stays pending and is taken later, and words leave in arrival order.
- R3: A destination with bit 15 clear writes the pattern RAM at `pat_addr` = destination[14:0]. After each word the destination steps by 1, wrapping from 0x7FFF to 0x0000.
- R4: Destination 0xFE00–0xFEFF writes the sprite RAM at `spr_addr` = destination[7:1]. The low byte then steps by 2 and wraps inside the page.
- R5: Destination 0xFF00–0xFF7F writes the palette RAM at `pal_addr` = destination[6:1]. 0xFF80–0xFFFF reach the same 64 entries, and the low byte steps by 2 with wrap inside the page.
- R6: A word popped at a destination in 0x8000–0xFDFF raises no strobe and is discarded. The low byte still steps by 2.
- R7: One word leaves the queue in each cycle where the queue is not empty and `mem_grant` is high. Its strobe is combinational in that cycle. The destination changes only when a word leaves or an address is written.
- R8: An address written while k words are queued (not counting a word leaving in that cycle) applies after those k words have left. A word pushed in the same cycle as the address write, or later, goes to the new destination.
- R9: `rd_data` returns the read data of the RAM selected by the current destination, and 0xFFFF when that destination is unmapped.
- R10: `status[0]` is queue empty and `status[1]` is queue full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Load a new destination address |
| addr_in | input | 16 | Destination address value |
| in_valid | input | 1 | Host data word offered |
| in_ready | output | 1 | Queue can take a word |
| in_data | input | 16 | Host data word |
| status | output | 2 | Bit 0 empty, bit 1 full |
| rd_data | output | 16 | Read data at current destination |
| mem_grant | input | 1 | Video memory free for a host write this cycle |
| pat_we | output | 1 | Pattern RAM write strobe |
| pat_addr | output | 15 | Pattern RAM word address |
| spr_we | output | 1 | Sprite RAM write strobe |
| spr_addr | output | 7 | Sprite RAM word address |
| pal_we | output | 1 | Palette RAM write strobe |
| pal_addr | output | 6 | Palette RAM word address |
| ram_wdata | output | 16 | Write data shared by all RAMs |
| pat_rdata | input | 16 | Pattern RAM read data |
| spr_rdata | input | 16 | Sprite RAM read data |
| pal_rdata | input | 16 | Palette RAM read data |

## Verification
The queue drains one word per cycle, so it can only fill, and a queued address change can only be seen, while the drain is stalled. The stimulus holds `mem_grant` low to fill all four slots and offers a fifth word against back-pressure, then releases the grant and follows the words out in order. In a second stall, two words are queued to the pattern RAM and a palette address is written behind them. Releasing the grant then shows the old destination serving the first two words and the new one taking effect only for the third.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
  typedef enum logic [1:0] {
    RGN_PAT  = 2'd0,
    RGN_SPR  = 2'd1,
    RGN_PAL  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam logic [7:0] SPR_PAGE = 8'hFE;
  localparam logic [7:0] PAL_PAGE = 8'hFF;
  localparam int unsigned OFS_W   = 8;
  localparam int unsigned OFS_STEP = 2;
endpackage

// File: rtl/vhp_fifo.sv
module vhp_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/vhp_decode.sv
module vhp_decode
  import vhp_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr,
  output region_e      region,
  output logic [AW-1:0] next_addr
);
  localparam int unsigned PAGE_W = AW - OFS_W;

  logic [PAGE_W-1:0] page;
  assign page = addr[AW-1:OFS_W];

  always_comb begin
    if (!addr[AW-1])             region = RGN_PAT;
    else if (page == SPR_PAGE)   region = RGN_SPR;
    else if (page == PAL_PAGE)   region = RGN_PAL;
    else                         region = RGN_NONE;
  end

  always_comb begin
    if (!addr[AW-1]) begin
      next_addr = {1'b0, addr[AW-2:0] + (AW-1)'(1)};
    end else begin
      next_addr = {page, addr[OFS_W-1:0] + OFS_W'(OFS_STEP)};
    end
  end
endmodule

// File: rtl/vhp_addr.sv
module vhp_addr #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_in,
  input  logic          pop,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] next_addr,
  output logic [AW-1:0] cur_addr,
  output logic          pend_valid
);
  logic [AW-1:0] pend_addr;
  logic [CW-1:0] ahead;
  logic [CW-1:0] ahead_now;

  assign ahead_now = count - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      pend_addr  <= '0;
      pend_valid <= 1'b0;
      ahead      <= '0;
    end else if (addr_we) begin
      if (ahead_now == '0) begin
        cur_addr   <= addr_in;
        pend_valid <= 1'b0;
      end else begin
        if (pop) cur_addr <= next_addr;
        pend_addr  <= addr_in;
        pend_valid <= 1'b1;
        ahead      <= ahead_now;
      end
    end else if (pop) begin
      if (pend_valid && ahead == CW'(1)) begin
        cur_addr   <= pend_addr;
        pend_valid <= 1'b0;
      end else begin
        cur_addr <= next_addr;
      end
      if (pend_valid) ahead <= ahead - CW'(1);
    end
  end
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
  import vhp_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PAT_AW = AW - 1,
  localparam int unsigned SPR_AW = OFS_W - 1,
  localparam int unsigned PAL_AW = OFS_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [AW-1:0]     addr_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic [1:0]        status,
  output logic [DW-1:0]     rd_data,
  input  logic              mem_grant,
  output logic              pat_we,
  output logic [PAT_AW-1:0] pat_addr,
  output logic              spr_we,
  output logic [SPR_AW-1:0] spr_addr,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     pat_rdata,
  input  logic [DW-1:0]     spr_rdata,
  input  logic [DW-1:0]     pal_rdata
);
  logic          q_empty, q_full, push, pop;
  logic [CW-1:0] q_count;
  logic [DW-1:0] q_head;
  logic [AW-1:0] cur_addr, next_addr;
  logic          pend_valid;
  region_e       region;

  assign in_ready = !q_full;
  assign push     = in_valid && in_ready;
  assign pop      = !q_empty && mem_grant;
  assign status   = {q_full, q_empty};

  vhp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(in_data),
    .pop(pop), .head(q_head), .count(q_count),
    .empty(q_empty), .full(q_full)
  );

  vhp_decode #(.AW(AW)) u_dec (
    .addr(cur_addr), .region(region), .next_addr(next_addr)
  );

  vhp_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .addr_we(addr_we), .addr_in(addr_in),
    .pop(pop), .count(q_count), .next_addr(next_addr),
    .cur_addr(cur_addr), .pend_valid(pend_valid)
  );

  assign pat_addr  = cur_addr[PAT_AW-1:0];
  assign spr_addr  = cur_addr[OFS_W-1:1];
  assign pal_addr  = cur_addr[OFS_W-2:1];
  assign ram_wdata = q_head;

  assign pat_we = pop && (region == RGN_PAT);
  assign spr_we = pop && (region == RGN_SPR);
  assign pal_we = pop && (region == RGN_PAL);

  always_comb begin
    unique case (region)
      RGN_PAT: rd_data = pat_rdata;
      RGN_SPR: rd_data = spr_rdata;
      RGN_PAL: rd_data = pal_rdata;
      default: rd_data = '1;
    endcase
  end
endmodule

// File: rtl/vram_host_port_chk.sv
module vram_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_we,
  input logic        in_ready,
  input logic [1:0]  status,
  input logic        mem_grant,
  input logic        pat_we,
  input logic [14:0] pat_addr,
  input logic        spr_we,
  input logic        pal_we,
  input logic        pend_valid
);
  a_r2_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> !in_ready);

  a_r10_empty_full_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_we, spr_we, pal_we}));

  a_r7_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_we || spr_we || pal_we) |-> (mem_grant && !status[0]));

  a_r7_addr_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((status[0] || !mem_grant) && !addr_we) |=> $stable(pat_addr));

  a_r3_pat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_we && !pend_valid && !addr_we) |=> (pat_addr == $past(pat_addr) + 15'd1));
endmodule

bind vram_host_port vram_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .in_ready(in_ready),
  .status(status), .mem_grant(mem_grant), .pat_we(pat_we),
  .pat_addr(pat_addr), .spr_we(spr_we), .pal_we(pal_we),
  .pend_valid(pend_valid)
);

// File: tb/vram_host_port_tb.sv
module vram_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_we = 1'b0;
  logic [15:0] addr_in = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [1:0]  status;
  logic [15:0] rd_data;
  logic        mem_grant = 1'b1;
  logic        pat_we, spr_we, pal_we;
  logic [14:0] pat_addr;
  logic [6:0]  spr_addr;
  logic [5:0]  pal_addr;
  logic [15:0] ram_wdata;
  logic [15:0] pat_rdata = 16'h1111;
  logic [15:0] spr_rdata = 16'h2222;
  logic [15:0] pal_rdata = 16'h3333;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vram_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_in(addr_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .status(status), .rd_data(rd_data), .mem_grant(mem_grant),
    .pat_we(pat_we), .pat_addr(pat_addr), .spr_we(spr_we), .spr_addr(spr_addr),
    .pal_we(pal_we), .pal_addr(pal_addr), .ram_wdata(ram_wdata),
    .pat_rdata(pat_rdata), .spr_rdata(spr_rdata), .pal_rdata(pal_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {dest, data, region(0 pat,1 spr,2 pal,3 none), port addr, next dest}
  localparam logic [65:0] VEC [10] = '{
    {16'h0123, 16'hA5A5, 2'd0, 16'h0123, 16'h0124},  // R3
    {16'h7FFF, 16'h5A5A, 2'd0, 16'h7FFF, 16'h0000},  // R3 wrap
    {16'hFE10, 16'h1234, 2'd1, 16'h0008, 16'hFE12},  // R4
    {16'hFEFE, 16'h4321, 2'd1, 16'h007F, 16'hFE00},  // R4 page wrap
    {16'hFE11, 16'h0F0F, 2'd1, 16'h0008, 16'hFE13},  // R4 bit 0 ignored
    {16'hFF04, 16'hBEEF, 2'd2, 16'h0002, 16'hFF06},  // R5
    {16'hFF84, 16'hCAFE, 2'd2, 16'h0002, 16'hFF86},  // R5 mirror
    {16'hFFFE, 16'h7777, 2'd2, 16'h003F, 16'hFF00},  // R5 page wrap
    {16'h8000, 16'hDEAD, 2'd3, 16'h0000, 16'h8002},  // R6
    {16'hFDFE, 16'hF00D, 2'd3, 16'h0000, 16'hFD00}   // R6 wrap
  };

  task automatic load_addr(input logic [15:0] a);
    @(negedge clk); addr_we = 1'b1; addr_in = a;
    @(negedge clk); addr_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_rd;
    logic [2:0]  exp_we;
    logic [15:0] port;
    logic        drop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    check("R1 strobes", {pat_we, spr_we, pal_we}, 3'b000);
    check("R1 dest", pat_addr, 15'h0000);
    check("R10 empty after reset", status, 2'b01);
    check("R2 ready after reset", in_ready, 1'b1);

    // table walk: R3 R4 R5 R6 R9
    for (int i = 0; i < 10; i++) begin
      logic [15:0] va, vd, vp, vn;
      logic [1:0]  vr;
      {va, vd, vr, vp, vn} = VEC[i];
      addr_we = 1'b1; addr_in = va;
      @(negedge clk); addr_we = 1'b0; in_valid = 1'b1; in_data = vd;
      @(negedge clk); in_valid = 1'b0;
      case (vr)
        2'd0: begin exp_we = 3'b100; exp_rd = 16'h1111; port = {1'b0, pat_addr}; end
        2'd1: begin exp_we = 3'b010; exp_rd = 16'h2222; port = {9'd0, spr_addr}; end
        2'd2: begin exp_we = 3'b001; exp_rd = 16'h3333; port = {10'd0, pal_addr}; end
        default: begin exp_we = 3'b000; exp_rd = 16'hFFFF; port = vp; end
      endcase
      check($sformatf("R3-6 strobe vec%0d", i), {pat_we, spr_we, pal_we}, exp_we);
      check($sformatf("R9 rd_data vec%0d", i), rd_data, exp_rd);
      if (vr != 2'd3) begin
        check($sformatf("R3-6 port addr vec%0d", i), port, vp);
        check($sformatf("R7 wdata vec%0d", i), ram_wdata, vd);
      end
      @(negedge clk);
      check($sformatf("R6 next dest vec%0d", i), pat_addr, vn[14:0]);
    end

    // R7: no grant, nothing leaves and the destination holds
    mem_grant = 1'b0;
    load_addr(16'h0040);
    in_valid = 1'b1; in_data = 16'h6060;
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 no strobe without grant", {pat_we, spr_we, pal_we}, 3'b000);
    check("R7 dest held", pat_addr, 15'h0040);
    check("R10 not empty", status, 2'b00);
    mem_grant = 1'b1; #1;
    check("R7 strobe on grant", pat_we, 1'b1);
    check("R7 data on grant", ram_wdata, 16'h6060);
    @(negedge clk);
    check("R7 dest stepped", pat_addr, 15'h0041);
    check("R10 empty again", status, 2'b01);

    // R2: fill the queue, offer a fifth word
    mem_grant = 1'b0;
    load_addr(16'h0100);
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_data = 16'hD000 + 16'(k);
      @(negedge clk);
    end
    in_data = 16'hD004;
    check("R2 ready low when full", in_ready, 1'b0);
    check("R10 full flag", status, 2'b10);
    @(negedge clk);
    check("R2 fifth word held off", in_ready, 1'b0);
    mem_grant = 1'b1; #1;
    drop = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check($sformatf("R2 order word%0d", k), ram_wdata, 16'hD000 + 16'(k));
      check($sformatf("R2 addr word%0d", k), pat_addr, 15'h0100 + 15'(k));
      if (drop) in_valid = 1'b0;
      drop = in_valid && in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R2 drained", status, 2'b01);

    // R8: queued address change
    mem_grant = 1'b0;
    load_addr(16'h0010);
    in_valid = 1'b1; in_data = 16'hAAAA;
    @(negedge clk); in_data = 16'hBBBB;
    @(negedge clk); in_valid = 1'b0; addr_we = 1'b1; addr_in = 16'hFF20;
    @(negedge clk); addr_we = 1'b0; in_valid = 1'b1; in_data = 16'hCCCC;
    @(negedge clk); in_valid = 1'b0;
    check("R8 old dest kept while queued", pat_addr, 15'h0010);
    mem_grant = 1'b1; #1;
    check("R8 first word pattern", {pat_we, ram_wdata}, {1'b1, 16'hAAAA});
    @(negedge clk);
    check("R8 second word pattern", {pat_we, ram_wdata, 1'b0, pat_addr}, {1'b1, 16'hBBBB, 16'h0011});
    @(negedge clk);
    check("R8 third word palette", {pal_we, ram_wdata}, {1'b1, 16'hCCCC});
    check("R8 palette index", pal_addr, 6'h10);
    @(negedge clk);
    check("R8 dest after switch", pal_addr, 6'h11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule